// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block works out the memory operand address for a 16-bit processor that uses segmented memory. From a request it takes an addressing mode, a pointer register select, an index register select, and the current values of the four address registers (BX, BP, SI, DI). It also takes a displacement with a width flag, the three data-side segment registers (DS, ES, SS) and an optional segment override. It combines pointer, index and displacement as the mode dictates and picks a segment from the registers that were used. The result is a 16-bit offset, a segment code and a 20-bit physical address.

The result is registered. A request with a memory-addressing mode produces a one-cycle valid pulse on the next clock, carrying the new result. A request with a mode code that names no memory address produces no pulse and leaves the outputs as they were. Between requests the outputs hold.

Top module: `seg_ea_gen`

## Requirements
- R1: While reset is asserted and after it is released, and before any request, `valid_o` is 0 and `off_o`, `seg_o` and `phys_o` are 0.
- R2: A request (`req_i`=1) with mode code 0 to 4 raises `valid_o` for exactly the next cycle. Mode codes 5, 6 and 7 do not raise `valid_o` and do not change any output.
- R3: Mode 0 (direct) uses all 16 bits of `disp_i` as the offset, whatever `disp_wide_i` is. The default segment is DS.
- R4: Mode 1 (register indirect) uses the pointer chosen by `ptr_sel_i` as the offset, with 0=BX, 1=BP, 2=SI and 3=DI. The default segment is DS for BX and SI, ES for DI and SS for BP. Selecting SI or DI gives the indexed form.
- R5: Mode 2 (register relative) adds the sized displacement to the pointer chosen by `ptr_sel_i`. The segment follows the same rule as R4.
- R6: When `disp_wide_i`=0, the displacement is `disp_i[7:0]` sign-extended to 16 bits and `disp_i[15:8]` is ignored. When `disp_wide_i`=1, all 16 bits are used.
- R7: Mode 3 (based indexed) adds a base register to an index register. The base is chosen by `ptr_sel_i[0]` (0=BX, 1=BP) and `ptr_sel_i[1]` is ignored. The index is chosen by `idx_sel_i` (0=SI, 1=DI). The default segment is SS when the base is BP and DS otherwise.
- R8: Mode 4 (relative based indexed) adds base, index and the sized displacement. It selects the base, the index and the segment as in R7.
- R9: All offset sums wrap modulo 2^16.
- R10: `phys_o` equals (segment value × 16 + `off_o`) modulo 2^20. `seg_o` reports the segment used, coded 0=DS, 1=ES, 2=SS.
- R11: When `ovr_en_i`=1 and `ovr_seg_i` is 0, 1 or 2, that segment replaces the default. An override code of 3 is ignored and the default applies.
- R12: Cycles without a request leave `off_o`, `seg_o` and `phys_o` unchanged and `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer select (BX, BP, SI, DI); bit 0 selects the base in the indexed modes |
| idx_sel_i | input | 1 | Index select: 0=SI, 1=DI |
| bx_i | input | 16 | BX contents |
| bp_i | input | 16 | BP contents |
| si_i | input | 16 | SI contents |
| di_i | input | 16 | DI contents |
| disp_i | input | 16 | Displacement or direct offset |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = sign-extended low byte |
| ds_i | input | 16 | DS value |
| es_i | input | 16 | ES value |
| ss_i | input | 16 | SS value |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment code |
| valid_o | output | 1 | Result valid pulse |
| off_o | output | 16 | Effective offset |
| seg_o | output | 2 | Segment used (0=DS, 1=ES, 2=SS) |
| phys_o | output | 20 | Physical address |

## Verification
Each pointer register is tried alone in the indirect mode, which shows whether the segment defaults of BX, BP, SI and DI are kept apart. Relative requests then use narrow displacements with bit 7 clear and bit 7 set, with junk in the upper byte, and also a wide displacement. Together these separate sign extension, upper-byte masking and full-width use. The indexed modes are run with BX and BP bases against SI and DI indices, and with operands chosen to carry out of bit 15 and out of bit 19, so that modulo wrapping is seen in both sums. Overrides with a legal code and with code 3, illegal mode codes, idle gaps and back-to-back requests show what the override changes and what leaves the registered outputs untouched.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT = 3'd0,
    AM_IND    = 3'd1,
    AM_REL    = 3'd2,
    AM_BIDX   = 3'd3,
    AM_RBIDX  = 3'd4
  } am_e;

  typedef enum logic [1:0] {
    SG_DS   = 2'd0,
    SG_ES   = 2'd1,
    SG_SS   = 2'd2,
    SG_NONE = 2'd3
  } sg_e;

  typedef enum logic [1:0] {
    PR_BX = 2'd0,
    PR_BP = 2'd1,
    PR_SI = 2'd2,
    PR_DI = 2'd3
  } pr_e;

endpackage

// File: rtl/ea_offset.sv
module ea_offset
  import ea_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int NARR_W = 8
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic             idx_sel,
  input  logic [OFF_W-1:0] bx,
  input  logic [OFF_W-1:0] bp,
  input  logic [OFF_W-1:0] si,
  input  logic [OFF_W-1:0] di,
  input  logic [OFF_W-1:0] disp,
  input  logic             disp_wide,
  output logic [OFF_W-1:0] off,
  output logic             legal
);

  localparam int EXT_W = OFF_W - NARR_W;

  logic [OFF_W-1:0] disp_ext;
  logic [OFF_W-1:0] ptr_val;
  logic [OFF_W-1:0] base_val;
  logic [OFF_W-1:0] idx_val;

  always_comb begin
    if (disp_wide) disp_ext = disp;
    else           disp_ext = {{EXT_W{disp[NARR_W-1]}}, disp[NARR_W-1:0]};
  end

  always_comb begin
    case (ptr_sel)
      PR_BX:   ptr_val = bx;
      PR_BP:   ptr_val = bp;
      PR_SI:   ptr_val = si;
      default: ptr_val = di;
    endcase
  end

  assign base_val = ptr_sel[0] ? bp : bx;
  assign idx_val  = idx_sel ? di : si;

  always_comb begin
    legal = 1'b1;
    case (mode)
      AM_DIRECT: off = disp;
      AM_IND:    off = ptr_val;
      AM_REL:    off = ptr_val + disp_ext;
      AM_BIDX:   off = base_val + idx_val;
      AM_RBIDX:  off = base_val + idx_val + disp_ext;
      default: begin
        off   = '0;
        legal = 1'b0;
      end
    endcase
  end

  // R6
  narrow_disp_chk: assert final (disp_wide || disp_ext[OFF_W-1:NARR_W] == {EXT_W{disp[NARR_W-1]}});

endmodule

// File: rtl/ea_seg_sel.sv
module ea_seg_sel
  import ea_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [1:0] ptr_sel,
  input  logic       ovr_en,
  input  logic [1:0] ovr_seg,
  output logic [1:0] seg
);

  logic [1:0] dflt;
  logic       ovr_ok;

  always_comb begin
    case (mode)
      AM_IND, AM_REL: begin
        case (ptr_sel)
          PR_BP:   dflt = SG_SS;
          PR_DI:   dflt = SG_ES;
          default: dflt = SG_DS;
        endcase
      end
      AM_BIDX, AM_RBIDX: dflt = ptr_sel[0] ? SG_SS : SG_DS;
      default:           dflt = SG_DS;
    endcase
  end

  assign ovr_ok = ovr_en && (ovr_seg != SG_NONE);
  assign seg    = ovr_ok ? ovr_seg : dflt;

  // R11
  seg_code_chk: assert final (seg != SG_NONE);

endmodule

// File: rtl/ea_phys.sv
module ea_phys
  import ea_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [1:0]                 seg,
  input  logic [OFF_W-1:0]           ds,
  input  logic [OFF_W-1:0]           es,
  input  logic [OFF_W-1:0]           ss,
  input  logic [OFF_W-1:0]           off,
  output logic [OFF_W+SEG_SHIFT-1:0] phys
);

  localparam int PA_W = OFF_W + SEG_SHIFT;

  logic [OFF_W-1:0] seg_val;

  always_comb begin
    case (seg)
      SG_ES:   seg_val = es;
      SG_SS:   seg_val = ss;
      default: seg_val = ds;
    endcase
  end

  assign phys = PA_W'({seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off});

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import ea_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int NARR_W    = 8,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [2:0]                 mode_i,
  input  logic [1:0]                 ptr_sel_i,
  input  logic                       idx_sel_i,
  input  logic [OFF_W-1:0]           bx_i,
  input  logic [OFF_W-1:0]           bp_i,
  input  logic [OFF_W-1:0]           si_i,
  input  logic [OFF_W-1:0]           di_i,
  input  logic [OFF_W-1:0]           disp_i,
  input  logic                       disp_wide_i,
  input  logic [OFF_W-1:0]           ds_i,
  input  logic [OFF_W-1:0]           es_i,
  input  logic [OFF_W-1:0]           ss_i,
  input  logic                       ovr_en_i,
  input  logic [1:0]                 ovr_seg_i,
  output logic                       valid_o,
  output logic [OFF_W-1:0]           off_o,
  output logic [1:0]                 seg_o,
  output logic [OFF_W+SEG_SHIFT-1:0] phys_o
);

  localparam int PA_W = OFF_W + SEG_SHIFT;

  logic [OFF_W-1:0] off_c;
  logic             legal_c;
  logic [1:0]       seg_c;
  logic [PA_W-1:0]  phys_c;
  logic             load;

  logic             valid_q, valid_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [1:0]       seg_q, seg_d;
  logic [PA_W-1:0]  phys_q, phys_d;

  ea_offset #(.OFF_W(OFF_W), .NARR_W(NARR_W)) u_off (
    .mode      (mode_i),
    .ptr_sel   (ptr_sel_i),
    .idx_sel   (idx_sel_i),
    .bx        (bx_i),
    .bp        (bp_i),
    .si        (si_i),
    .di        (di_i),
    .disp      (disp_i),
    .disp_wide (disp_wide_i),
    .off       (off_c),
    .legal     (legal_c)
  );

  ea_seg_sel u_seg (
    .mode    (mode_i),
    .ptr_sel (ptr_sel_i),
    .ovr_en  (ovr_en_i),
    .ovr_seg (ovr_seg_i),
    .seg     (seg_c)
  );

  ea_phys #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg  (seg_c),
    .ds   (ds_i),
    .es   (es_i),
    .ss   (ss_i),
    .off  (off_c),
    .phys (phys_c)
  );

  assign load = req_i && legal_c;

  always_comb begin
    valid_d = load;
    off_d   = off_q;
    seg_d   = seg_q;
    phys_d  = phys_q;
    if (load) begin
      off_d  = off_c;
      seg_d  = seg_c;
      phys_d = phys_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      off_q   <= '0;
      seg_q   <= '0;
      phys_q  <= '0;
    end else begin
      valid_q <= valid_d;
      off_q   <= off_d;
      seg_q   <= seg_d;
      phys_q  <= phys_d;
    end
  end

  assign valid_o = valid_q;
  assign off_o   = off_q;
  assign seg_o   = seg_q;
  assign phys_o  = phys_q;

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i <= 3'd4) |=> valid_o);

  // R2
  no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && mode_i <= 3'd4) |=> (!valid_o && $stable(off_o) && $stable(seg_o) && $stable(phys_o)));

  // R10
  phys_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> phys_o == PA_W'({(seg_o == SG_ES) ? $past(es_i) : (seg_o == SG_SS) ? $past(ss_i) : $past(ds_i),
                                 {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off_o}));

  // R11
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i <= 3'd4 && ovr_en_i && ovr_seg_i != SG_NONE) |=> seg_o == $past(ovr_seg_i));

  // R3
  direct_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == AM_DIRECT) |=> off_o == $past(disp_i));

endmodule

// File: tb/seg_ea_gen_test.sv
module seg_ea_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [2:0]  mode_i;
  logic [1:0]  ptr_sel_i;
  logic        idx_sel_i;
  logic [15:0] bx_i, bp_i, si_i, di_i, disp_i, ds_i, es_i, ss_i;
  logic        disp_wide_i;
  logic        ovr_en_i;
  logic [1:0]  ovr_seg_i;
  logic        valid_o;
  logic [15:0] off_o;
  logic [1:0]  seg_o;
  logic [19:0] phys_o;

  int errors = 0;
  int checks = 0;

  logic [15:0] q_off[$];
  logic [1:0]  q_seg[$];
  logic [19:0] q_pa[$];
  string       q_tag[$];
  logic [15:0] last_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .ptr_sel_i(ptr_sel_i), .idx_sel_i(idx_sel_i),
    .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
    .disp_i(disp_i), .disp_wide_i(disp_wide_i),
    .ds_i(ds_i), .es_i(es_i), .ss_i(ss_i),
    .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
    .valid_o(valid_o), .off_o(off_o), .seg_o(seg_o), .phys_o(phys_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent reference of the requirements
  task automatic send(input logic [2:0] m, input logic [1:0] p, input logic ix,
                      input logic [15:0] d, input logic w,
                      input logic oe, input logic [1:0] os, input string tag);
    int dv, b, x, r, o, sv;
    int sg;
    mode_i = m; ptr_sel_i = p; idx_sel_i = ix; disp_i = d; disp_wide_i = w;
    ovr_en_i = oe; ovr_seg_i = os; req_i = 1'b1;
    if (m <= 3'd4) begin
      dv = w ? int'(d) : (d[7] ? int'(d[7:0]) - 256 : int'(d[7:0]));
      r  = (p == 2'd0) ? int'(bx_i) : (p == 2'd1) ? int'(bp_i) : (p == 2'd2) ? int'(si_i) : int'(di_i);
      b  = p[0] ? int'(bp_i) : int'(bx_i);
      x  = ix ? int'(di_i) : int'(si_i);
      case (m)
        3'd0: begin o = int'(d);     sg = 0; end
        3'd1: begin o = r;           sg = (p == 2'd1) ? 2 : (p == 2'd3) ? 1 : 0; end
        3'd2: begin o = r + dv;      sg = (p == 2'd1) ? 2 : (p == 2'd3) ? 1 : 0; end
        3'd3: begin o = b + x;       sg = p[0] ? 2 : 0; end
        default: begin o = b + x + dv; sg = p[0] ? 2 : 0; end
      endcase
      o = o & 32'hFFFF;
      if (oe && os != 2'd3) sg = int'(os);
      sv = (sg == 1) ? int'(es_i) : (sg == 2) ? int'(ss_i) : int'(ds_i);
      q_off.push_back(o[15:0]);
      q_seg.push_back(sg[1:0]);
      q_pa.push_back(20'((sv * 16 + o) & 32'hFFFFF));
      q_tag.push_back(tag);
      last_off = o[15:0];
    end
    @(posedge clk);
    @(negedge clk);
    if (m > 3'd4) begin
      // R2: illegal mode gives no pulse and no output change
      chk({tag, " valid"}, 32'(valid_o), 32'd0);
      chk({tag, " hold"}, 32'(off_o), 32'(last_off));
    end
  endtask

  task automatic idle(input string tag);
    req_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " valid"}, 32'(valid_o), 32'd0);
    chk({tag, " hold"}, 32'(off_o), 32'(last_off));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && valid_o === 1'b1) begin
      if (q_off.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected valid actual=1 expected=0");
      end else begin
        automatic string t = q_tag.pop_front();
        chk({t, " offset"}, 32'(off_o), 32'(q_off.pop_front()));
        chk({t, " segment"}, 32'(seg_o), 32'(q_seg.pop_front()));
        chk({t, " R10 phys"}, 32'(phys_o), 32'(q_pa.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; mode_i = '0; ptr_sel_i = '0; idx_sel_i = 1'b0;
    disp_i = '0; disp_wide_i = 1'b0; ovr_en_i = 1'b0; ovr_seg_i = '0;
    bx_i = 16'h1234; bp_i = 16'h2000; si_i = 16'h0010; di_i = 16'h0F00;
    ds_i = 16'h1000; es_i = 16'h2000; ss_i = 16'h3000;
    last_off = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", 32'(valid_o), 32'd0);
    chk("R1 off", 32'(off_o), 32'd0);
    chk("R1 phys", 32'(phys_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 32'(valid_o), 32'd0);
    chk("R1 seg after release", 32'(seg_o), 32'd0);

    send(3'd0, 2'd0, 1'b0, 16'h5000, 1'b0, 1'b0, 2'd0, "R3 direct");
    send(3'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, "R4 BX");
    send(3'd1, 2'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, "R4 BP");
    send(3'd1, 2'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, "R4 SI");
    send(3'd1, 2'd3, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, "R4 DI");
    idle("R12 gap");
    send(3'd2, 2'd0, 1'b0, 16'h0050, 1'b0, 1'b0, 2'd0, "R5 BX+50");
    send(3'd2, 2'd2, 1'b0, 16'h0080, 1'b0, 1'b0, 2'd0, "R6 negative byte");
    send(3'd2, 2'd3, 1'b0, 16'hAB7F, 1'b0, 1'b0, 2'd0, "R6 upper ignored");
    send(3'd2, 2'd1, 1'b0, 16'h1234, 1'b1, 1'b0, 2'd0, "R5 wide BP");
    send(3'd3, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, "R7 BX+SI");
    send(3'd3, 2'd3, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0, "R7 BP+DI");
    send(3'd4, 2'd0, 1'b0, 16'h0050, 1'b0, 1'b0, 2'd0, "R8 BX+SI+50");
    send(3'd4, 2'd1, 1'b0, 16'h00FF, 1'b0, 1'b0, 2'd0, "R8 BP+SI-1");
    idle("R12 gap2");
    bx_i = 16'hFFF0; si_i = 16'h0020;
    send(3'd3, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, "R9 wrap");
    send(3'd2, 2'd0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 2'd0, "R9 wrap wide");
    ds_i = 16'hFFFF;
    send(3'd0, 2'd0, 1'b0, 16'h0020, 1'b1, 1'b0, 2'd0, "R10 phys wrap");
    send(3'd2, 2'd1, 1'b0, 16'h0004, 1'b0, 1'b1, 2'd0, "R11 BP to DS");
    send(3'd0, 2'd0, 1'b0, 16'h0100, 1'b0, 1'b1, 2'd1, "R11 direct to ES");
    send(3'd1, 2'd3, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd3, "R11 code3 ignored");
    send(3'd5, 2'd0, 1'b0, 16'h1111, 1'b0, 1'b0, 2'd0, "R2 mode5");
    send(3'd6, 2'd0, 1'b0, 16'h2222, 1'b0, 1'b0, 2'd0, "R2 mode6");
    send(3'd7, 2'd0, 1'b0, 16'h3333, 1'b0, 1'b0, 2'd0, "R2 mode7");
    idle("R12 end");
    idle("R12 end2");
    chk("R2 all results seen", 32'(q_off.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule